// File: doc/BRIEF.md
# Three-Level Hashed Flow Classifier

The block resolves a packet header (source address, destination address, source port, destination port) into a stored 16-bit per-flow value. The flow identity is an 80-bit key made of both addresses and the smaller of the two ports; the protocol plays no part. The lookup walks three tables in turn. The first is indexed directly by the top bits of the destination. The second is a 256-entry table picked by the first, indexed by an XOR fold of the remaining destination bits. The third is a 1,120-bucket table picked by the second, indexed by an XOR fold of source and port reduced modulo 1,120. Each bucket has seven slots, and the slots are told apart by a stored identifier.

An unknown flow is inserted on the fly. Missing second- and third-level tables are taken in order from fixed internal pools, and the flow goes into the first empty slot of its bucket with value zero. The response carries hit, error, the value and the slot location. A consumer that updates the value, such as a rate limiter or a deficit scheduler, sends the location back together with the new value on the write-back port. One lookup runs at a time. The controller moves from INIT (clearing the tables after reset) to IDLE, then through L1RD, L2RD, L3RD and SCAN to RESP, and back to IDLE. The transitions are: INIT to IDLE when the sweep ends; IDLE to L1RD on an accepted header; L2RD or L3RD to RESP when a pool is empty; SCAN to RESP on a match or after the last slot; RESP to IDLE always.

Top module: `flowcls_top`

## Requirements
- R1: The flow key is {source address, destination address, min(source port, destination port)}, so swapping the two ports yields the same flow.
- R2: The first level is indexed by destination bits [31:22]. The second-level index is the 8-bit XOR fold of destination bits [21:0], where output bit i is the XOR of all input bits j with j mod 8 = i.
- R3: The bucket index is the 11-bit XOR fold (same rule, j mod 11) of the 48-bit value {source, port}, minus 1120 when it is 1120 or more.
- R4: An unknown flow with room returns done with hit=0, err=0, value 0, and location {table[14], bucket[13:3], slot[2:0]}, where slot is the lowest empty slot of its bucket.
- R5: A lookup of a stored flow returns hit=1, its stored value and its original location.
- R6: A write-back (wb_valid with a location and a value) replaces only that slot's value, and later lookups of the flow return it.
- R7: When wb_valid and in_valid are both high while ready, only the write-back is taken and ready stays high in the next cycle.
- R8: A new flow whose bucket already holds 7 flows returns err=1 and hit=0, and is not stored. The flows already in the bucket still hit.
- R9: Second- and third-level tables are taken from pools of 4 and 2 in increasing order from 0. A lookup that needs a table from an empty pool returns err=1.
- R10: After reset, in_ready is low and rsp_valid is low while the tables are cleared, and then in_ready rises. in_ready is high only when no lookup is in progress. rsp_valid is a one-cycle pulse.
- R11: Distinct flows that share a bucket occupy slots 0, 1, 2, ... in order of arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Block idle, header or write-back taken |
| in_src | input | 32 | Source address |
| in_dst | input | 32 | Destination address |
| in_sport | input | 16 | Source port |
| in_dport | input | 16 | Destination port |
| wb_valid | input | 1 | Write-back request |
| wb_loc | input | 15 | Location {table, bucket, slot} to update |
| wb_value | input | 16 | New flow value |
| rsp_valid | output | 1 | Done strobe |
| rsp_hit | output | 1 | Flow was already stored |
| rsp_err | output | 1 | Bucket full or pool empty |
| rsp_value | output | 16 | Flow value |
| rsp_loc | output | 15 | Flow location {table, bucket, slot} |

## Verification
The assertions check the handshake rules on every cycle. These are: done lasts one cycle, an accepted header drops ready, a write-back keeps the block idle, an error never comes with a hit, a fresh insert reports value zero at a slot below seven, and the pool counters stay within bounds. Only the bench scenarios can show that the hashes, the slot order, the stored values, bucket overflow and pool exhaustion match a model of the tables built from the requirements. They do this with directed corner cases and seeded random traffic over a small key set that forces collisions.

// File: rtl/flowcls_pkg.sv
package flowcls_pkg;
    localparam int unsigned IP_W   = 32;
    localparam int unsigned PORT_W = 16;
    localparam int unsigned KEY_W  = 2 * IP_W + PORT_W;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_L1RD,
        ST_L2RD,
        ST_L3RD,
        ST_SCAN,
        ST_RESP
    } fc_state_e;
endpackage

// File: rtl/flowcls_keygen.sv
module flowcls_keygen
    import flowcls_pkg::*;
#(
    parameter int unsigned L1_W  = 10,
    localparam int unsigned RES_W = IP_W - L1_W,
    localparam int unsigned SP_W  = IP_W + PORT_W,
    localparam int unsigned ID_W  = RES_W + SP_W
) (
    input  logic [IP_W-1:0]   src,
    input  logic [IP_W-1:0]   dst,
    input  logic [PORT_W-1:0] sport,
    input  logic [PORT_W-1:0] dport,
    output logic [L1_W-1:0]   l1_idx,
    output logic [RES_W-1:0]  resid,
    output logic [SP_W-1:0]   srcport,
    output logic [ID_W-1:0]   id
);
    logic [PORT_W-1:0] low_port;

    assign low_port = (sport < dport) ? sport : dport;
    assign l1_idx   = dst[IP_W-1 -: L1_W];
    assign resid    = dst[RES_W-1:0];
    assign srcport  = {src, low_port};
    assign id       = {resid, srcport};
endmodule

// File: rtl/flowcls_fold.sv
module flowcls_fold #(
    parameter int unsigned IN_W  = 22,
    parameter int unsigned OUT_W = 8,
    localparam int unsigned NCH   = (IN_W + OUT_W - 1) / OUT_W,
    localparam int unsigned PAD_W = NCH * OUT_W
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    logic [PAD_W-1:0] padded;
    logic [OUT_W-1:0] chain [NCH+1];

    assign padded   = PAD_W'(din);
    assign chain[0] = '0;

    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        assign chain[g+1] = chain[g] ^ padded[g*OUT_W +: OUT_W];
    end

    assign dout = chain[NCH];
endmodule

// File: rtl/flowcls_modred.sv
module flowcls_modred #(
    parameter int unsigned MODULUS = 1120,
    localparam int unsigned W = $clog2(MODULUS)
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic ge;

    assign ge   = din >= W'(MODULUS);
    assign dout = ge ? din - W'(MODULUS) : din;
endmodule

// File: rtl/flowcls_top.sv
module flowcls_top
    import flowcls_pkg::*;
#(
    parameter int unsigned L1_W      = 10,
    parameter int unsigned L2_W      = 8,
    parameter int unsigned BUCKETS   = 1120,
    parameter int unsigned SLOTS     = 7,
    parameter int unsigned VAL_W     = 16,
    parameter int unsigned L2_TABLES = 4,
    parameter int unsigned L3_TABLES = 2,
    localparam int unsigned L2P_W = (L2_TABLES > 1) ? $clog2(L2_TABLES) : 1,
    localparam int unsigned L3P_W = (L3_TABLES > 1) ? $clog2(L3_TABLES) : 1,
    localparam int unsigned B_W   = $clog2(BUCKETS),
    localparam int unsigned S_W   = $clog2(SLOTS),
    localparam int unsigned LOC_W = L3P_W + B_W + S_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IP_W-1:0]   in_src,
    input  logic [IP_W-1:0]   in_dst,
    input  logic [PORT_W-1:0] in_sport,
    input  logic [PORT_W-1:0] in_dport,
    input  logic              wb_valid,
    input  logic [LOC_W-1:0]  wb_loc,
    input  logic [VAL_W-1:0]  wb_value,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [VAL_W-1:0]  rsp_value,
    output logic [LOC_W-1:0]  rsp_loc
);
    localparam int unsigned RES_W    = IP_W - L1_W;
    localparam int unsigned SP_W     = IP_W + PORT_W;
    localparam int unsigned ID_W     = RES_W + SP_W;
    localparam int unsigned SLOT_W   = 1 + ID_W + VAL_W;
    localparam int unsigned L1_DEPTH = 1 << L1_W;
    localparam int unsigned L2_ROWS  = L2_TABLES << L2_W;
    localparam int unsigned L2A_W    = L2P_W + L2_W;
    localparam int unsigned L3_ROWS  = L3_TABLES * BUCKETS;
    localparam int unsigned L3A_W    = $clog2(L3_ROWS);
    localparam int unsigned INIT_N   = (L1_DEPTH > L2_ROWS)
                                     ? ((L1_DEPTH > L3_ROWS) ? L1_DEPTH : L3_ROWS)
                                     : ((L2_ROWS > L3_ROWS) ? L2_ROWS : L3_ROWS);
    localparam int unsigned IC_W     = $clog2(INIT_N + 1);

    fc_state_e state, state_nx;

    logic [L2P_W:0]  l1_mem [L1_DEPTH];
    logic [L3P_W:0]  l2_mem [L2_ROWS];
    logic [SLOTS-1:0][SLOT_W-1:0] l3_mem [L3_ROWS];

    logic [IC_W-1:0]   init_cnt;
    logic [L2P_W:0]    l2_next;
    logic [L3P_W:0]    l3_next;
    logic [IP_W-1:0]   src_q, dst_q;
    logic [PORT_W-1:0] sp_q, dp_q;
    logic [L2P_W:0]    l1_rd;
    logic [L3P_W:0]    l2_rd;
    logic [SLOTS-1:0][SLOT_W-1:0] row_q;
    logic [L2A_W-1:0]  l2_addr_q;
    logic [L3A_W-1:0]  row_addr_q;
    logic [L3P_W-1:0]  l3ptr_q;
    logic [S_W-1:0]    sc, free_slot;
    logic              free_found;

    // key and hashes
    logic [L1_W-1:0]  l1_idx;
    logic [RES_W-1:0] resid;
    logic [SP_W-1:0]  srcport;
    logic [ID_W-1:0]  id;
    logic [L2_W-1:0]  h2;
    logic [B_W-1:0]   h3_fold, bucket;

    flowcls_keygen #(.L1_W(L1_W)) u_key (
        .src(src_q), .dst(dst_q), .sport(sp_q), .dport(dp_q),
        .l1_idx(l1_idx), .resid(resid), .srcport(srcport), .id(id)
    );

    flowcls_fold #(.IN_W(RES_W), .OUT_W(L2_W)) u_h2 (.din(resid), .dout(h2));
    flowcls_fold #(.IN_W(SP_W), .OUT_W(B_W)) u_h3 (.din(srcport), .dout(h3_fold));
    flowcls_modred #(.MODULUS(BUCKETS)) u_mod (.din(h3_fold), .dout(bucket));

    // per-level decisions
    logic              l2_need, l2_exh, l3_need, l3_exh;
    logic [L2P_W-1:0]  l2_sel;
    logic [L3P_W-1:0]  l3_sel;
    logic [L2A_W-1:0]  l2_addr;
    logic [L3A_W-1:0]  row_sel;
    logic [SLOT_W-1:0] cur;
    logic              cur_v, match, last_slot, ins_ok;
    logic [S_W-1:0]    ins_slot;
    logic [L3P_W-1:0]  wb_tbl;
    logic [B_W-1:0]    wb_bkt;
    logic [S_W-1:0]    wb_slot;
    logic [L3A_W-1:0]  wb_row;

    assign l2_need   = !l1_rd[L2P_W];
    assign l2_exh    = l2_need && (l2_next == (L2P_W+1)'(L2_TABLES));
    assign l2_sel    = l2_need ? l2_next[L2P_W-1:0] : l1_rd[L2P_W-1:0];
    assign l2_addr   = {l2_sel, h2};
    assign l3_need   = !l2_rd[L3P_W];
    assign l3_exh    = l3_need && (l3_next == (L3P_W+1)'(L3_TABLES));
    assign l3_sel    = l3_need ? l3_next[L3P_W-1:0] : l2_rd[L3P_W-1:0];
    assign row_sel   = L3A_W'(l3_sel) * L3A_W'(BUCKETS) + L3A_W'(bucket);
    assign cur       = row_q[sc];
    assign cur_v     = cur[SLOT_W-1];
    assign match     = cur_v && (cur[VAL_W +: ID_W] == id);
    assign last_slot = sc == S_W'(SLOTS - 1);
    assign ins_ok    = free_found || !cur_v;
    assign ins_slot  = free_found ? free_slot : sc;
    assign wb_tbl    = wb_loc[LOC_W-1 -: L3P_W];
    assign wb_bkt    = wb_loc[S_W +: B_W];
    assign wb_slot   = wb_loc[S_W-1:0];
    assign wb_row    = L3A_W'(wb_tbl) * L3A_W'(BUCKETS) + L3A_W'(wb_bkt);

    assign in_ready  = state == ST_IDLE;
    assign rsp_valid = state == ST_RESP;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT: if (init_cnt == IC_W'(INIT_N - 1)) state_nx = ST_IDLE;
            ST_IDLE: if (in_valid && !wb_valid) state_nx = ST_L1RD;
            ST_L1RD: state_nx = ST_L2RD;
            ST_L2RD: state_nx = l2_exh ? ST_RESP : ST_L3RD;
            ST_L3RD: state_nx = l3_exh ? ST_RESP : ST_SCAN;
            ST_SCAN: if (match || last_slot) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_INIT;
        endcase
    end

    // control and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt   <= '0;
            l2_next    <= '0;
            l3_next    <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            sp_q       <= '0;
            dp_q       <= '0;
            l2_addr_q  <= '0;
            row_addr_q <= '0;
            l3ptr_q    <= '0;
            sc         <= '0;
            free_slot  <= '0;
            free_found <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_value  <= '0;
            rsp_loc    <= '0;
        end else begin
            unique case (state)
                ST_INIT: init_cnt <= init_cnt + 1'b1;
                ST_IDLE: begin
                    if (in_valid && !wb_valid) begin
                        src_q <= in_src;
                        dst_q <= in_dst;
                        sp_q  <= in_sport;
                        dp_q  <= in_dport;
                    end
                end
                ST_L2RD: begin
                    l2_addr_q <= l2_addr;
                    if (l2_exh) begin
                        rsp_hit   <= 1'b0;
                        rsp_err   <= 1'b1;
                        rsp_value <= '0;
                        rsp_loc   <= '0;
                    end else if (l2_need) begin
                        l2_next <= l2_next + 1'b1;
                    end
                end
                ST_L3RD: begin
                    if (l3_exh) begin
                        rsp_hit   <= 1'b0;
                        rsp_err   <= 1'b1;
                        rsp_value <= '0;
                        rsp_loc   <= '0;
                    end else begin
                        if (l3_need) l3_next <= l3_next + 1'b1;
                        l3ptr_q    <= l3_sel;
                        row_addr_q <= row_sel;
                        sc         <= '0;
                        free_found <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (match) begin
                        rsp_hit   <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_value <= cur[VAL_W-1:0];
                        rsp_loc   <= {l3ptr_q, bucket, sc};
                    end else if (last_slot) begin
                        rsp_hit   <= 1'b0;
                        rsp_err   <= !ins_ok;
                        rsp_value <= '0;
                        rsp_loc   <= ins_ok ? {l3ptr_q, bucket, ins_slot} : '0;
                    end else begin
                        sc <= sc + 1'b1;
                        if (!cur_v && !free_found) begin
                            free_found <= 1'b1;
                            free_slot  <= sc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // table writes
    always_ff @(posedge clk) begin
        unique case (state)
            ST_INIT: begin
                if (init_cnt < IC_W'(L1_DEPTH)) l1_mem[init_cnt[L1_W-1:0]] <= '0;
                if (init_cnt < IC_W'(L2_ROWS))  l2_mem[init_cnt[L2A_W-1:0]] <= '0;
                if (init_cnt < IC_W'(L3_ROWS))  l3_mem[init_cnt[L3A_W-1:0]] <= '0;
            end
            ST_IDLE: if (wb_valid) l3_mem[wb_row][wb_slot][VAL_W-1:0] <= wb_value;
            ST_L2RD: if (l2_need && !l2_exh) l1_mem[l1_idx] <= {1'b1, l2_next[L2P_W-1:0]};
            ST_L3RD: if (l3_need && !l3_exh) l2_mem[l2_addr_q] <= {1'b1, l3_next[L3P_W-1:0]};
            ST_SCAN: if (!match && last_slot && ins_ok)
                         l3_mem[row_addr_q][ins_slot] <= {1'b1, id, VAL_W'(0)};
            default: ;
        endcase
    end

    // table reads
    always_ff @(posedge clk) begin
        if (state == ST_L1RD) l1_rd <= l1_mem[l1_idx];
        if (state == ST_L2RD) l2_rd <= l2_mem[l2_addr];
        if (state == ST_L3RD) row_q <= l3_mem[row_sel];
    end

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R10: an accepted header makes the block busy
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && !wb_valid) |=> !in_ready);
    // R7: a write-back keeps the block idle
    a_r7_wb_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && wb_valid) |=> in_ready);
    // R8: an error never comes with a hit
    a_r8_err_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !rsp_hit);
    // R4: a fresh insert reports value zero and a real slot
    a_r4_insert_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_err) |->
            (rsp_value == '0 && rsp_loc[S_W-1:0] < S_W'(SLOTS)));
    // R9: pools are never over-allocated
    a_r9_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_next <= (L2P_W+1)'(L2_TABLES)) && (l3_next <= (L3P_W+1)'(L3_TABLES)));
endmodule

// File: tb/flowcls_top_tb.sv
module flowcls_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_src = '0, in_dst = '0;
    logic [15:0] in_sport = '0, in_dport = '0;
    logic        wb_valid = 1'b0;
    logic [14:0] wb_loc = '0;
    logic [15:0] wb_value = '0;
    logic        rsp_valid, rsp_hit, rsp_err;
    logic [15:0] rsp_value;
    logic [14:0] rsp_loc;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flowcls_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_dst(in_dst), .in_sport(in_sport), .in_dport(in_dport),
        .wb_valid(wb_valid), .wb_loc(wb_loc), .wb_value(wb_value),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .rsp_value(rsp_value), .rsp_loc(rsp_loc)
    );

    // reference model of the tables
    int m_l1 [int];
    int m_l2 [int];
    int m_cnt [int];
    int m_loc [bit [79:0]];
    int m_val [int];
    int m_l2_next = 0;
    int m_l3_next = 0;

    function automatic int fold(bit [63:0] v, int in_w, int out_w);
        int r = 0;
        for (int j = 0; j < in_w; j++) if (v[j]) r ^= (1 << (j % out_w));
        return r;
    endfunction

    function automatic int bucket_of(bit [31:0] s, bit [15:0] p);
        int f = fold({16'h0, s, p}, 48, 11);
        return (f >= 1120) ? f - 1120 : f;
    endfunction

    function automatic void predict(bit [31:0] s, bit [31:0] d, bit [15:0] sp, bit [15:0] dp,
                                    output bit hit, output bit err, output int val, output int loc);
        bit [15:0] p = (sp < dp) ? sp : dp;
        bit [79:0] key = {s, d, p};
        int l1i, p2, k2, p3, b, row, c;
        hit = 0; err = 0; val = 0; loc = 0;
        if (m_loc.exists(key)) begin
            hit = 1; loc = m_loc[key]; val = m_val[loc];
            return;
        end
        l1i = int'(d[31:22]);
        if (!m_l1.exists(l1i)) begin
            if (m_l2_next == 4) begin err = 1; return; end
            m_l1[l1i] = m_l2_next; m_l2_next++;
        end
        p2 = m_l1[l1i];
        k2 = p2 * 256 + fold({42'h0, d[21:0]}, 22, 8);
        if (!m_l2.exists(k2)) begin
            if (m_l3_next == 2) begin err = 1; return; end
            m_l2[k2] = m_l3_next; m_l3_next++;
        end
        p3 = m_l2[k2];
        b = bucket_of(s, p);
        row = p3 * 1120 + b;
        c = m_cnt.exists(row) ? m_cnt[row] : 0;
        if (c == 7) begin err = 1; return; end
        m_cnt[row] = c + 1;
        loc = (p3 << 14) | (b << 3) | c;
        m_loc[key] = loc;
        m_val[loc] = 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int last_loc = -1;

    task automatic lookup(bit [31:0] s, bit [31:0] d, bit [15:0] sp, bit [15:0] dp, string req);
        bit eh, ee; int ev, el; int n = 0;
        predict(s, d, sp, dp, eh, ee, ev, el);
        while (!in_ready) @(negedge clk);
        in_src = s; in_dst = d; in_sport = sp; in_dport = dp; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
        check(rsp_valid, {req, " done"}, int'(rsp_valid), 1);
        check(rsp_hit == eh && rsp_err == ee, {req, " hit/err"},
              int'({rsp_hit, rsp_err}), int'({eh, ee}));
        check(int'(rsp_value) == ev, {req, " value"}, int'(rsp_value), ev);
        if (!ee) begin
            check(int'(rsp_loc) == el, {req, " loc"}, int'(rsp_loc), el);
            last_loc = el;
        end
        @(negedge clk);
        check(!rsp_valid, "R10 done pulse", int'(rsp_valid), 0);
    endtask

    task automatic writeback(int loc, bit [15:0] v);
        while (!in_ready) @(negedge clk);
        wb_loc = 15'(loc); wb_value = v; wb_valid = 1'b1;
        @(negedge clk);
        wb_valid = 1'b0;
        m_val[loc] = int'(v);
    endtask

    function automatic bit [31:0] spread(int m);
        bit [31:0] r = '0;
        for (int k = 0; k < 3; k++) if (m[k]) r |= (32'h1 << k) | (32'h1 << (k + 11));
        return r;
    endfunction

    localparam bit [31:0] D0 = 32'h0A40_0001;
    localparam bit [31:0] S0 = 32'hC0A8_0105;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready && !rsp_valid, "R10 reset state", int'({in_ready, rsp_valid}), 0);
        begin
            int n = 0;
            while (!in_ready && n < 5000) begin @(negedge clk); n++; end
            check(in_ready, "R10 ready after clear", int'(in_ready), 1);
        end

        // R4 new flow, R5 repeat, R1 port swap
        lookup(S0, D0, 16'd1234, 16'd80, "R4 first insert");
        lookup(S0, D0, 16'd1234, 16'd80, "R5 repeat hit");
        lookup(S0, D0, 16'd80, 16'd1234, "R1 swapped ports");
        check(bucket_of(S0, 16'd80) < 1120, "R3 bucket range", bucket_of(S0, 16'd80), 0);

        // R6 write-back
        writeback(last_loc, 16'hBEEF);
        lookup(S0, D0, 16'd1234, 16'd80, "R6 value after write-back");

        // R7 write-back priority over a header in the same cycle
        while (!in_ready) @(negedge clk);
        wb_loc = 15'(last_loc); wb_value = 16'h1111; wb_valid = 1'b1;
        in_src = 32'h0101_0101; in_dst = D0; in_sport = 16'd7; in_dport = 16'd9; in_valid = 1'b1;
        @(negedge clk);
        wb_valid = 1'b0; in_valid = 1'b0;
        m_val[last_loc] = 32'h1111;
        check(in_ready && !rsp_valid, "R7 header not taken", int'({in_ready, rsp_valid}), 2);
        lookup(S0, D0, 16'd1234, 16'd80, "R7 write-back applied");

        // R11 ordered slots, R8 bucket overflow
        for (int m = 1; m < 8; m++) lookup(S0 ^ spread(m), D0, 16'd80, 16'd443, "R11 R8 bucket fill");
        lookup(S0 ^ spread(3), D0, 16'd80, 16'd443, "R8 existing still hit");

        // R2 second-level collision shares the table, R9 pool exhaustion
        lookup(32'h1234_5678, D0 ^ 32'h0000_0101, 16'd22, 16'd5000, "R2 shared L2 entry");
        lookup(S0, D0 ^ 32'h2, 16'd80, 16'd443, "R9 second L3 table");
        lookup(S0, D0 ^ 32'h4, 16'd80, 16'd443, "R9 L3 pool empty");
        for (int k = 1; k < 5; k++) lookup(S0, D0 + (32'(k) << 22), 16'd80, 16'd443, "R9 L2 pool");

        // seeded random traffic over a small key set
        for (int i = 0; i < 300; i++) begin
            bit [31:0] d, s;
            bit [15:0] sp, dp;
            int r = int'($urandom % 3);
            d = (r == 0) ? D0 : (r == 1) ? (D0 ^ 32'h2) : (D0 ^ 32'h0000_0101);
            s = ($urandom % 2) ? (S0 ^ spread(int'($urandom % 8))) : (32'h0A00_0000 + ($urandom % 16));
            sp = 16'(($urandom % 4) * 1000 + 22);
            dp = 16'(($urandom % 4) * 1000 + 80);
            lookup(s, d, sp, dp, "R5 R4 random");
            if (($urandom % 4) == 0 && last_loc >= 0) writeback(last_loc, 16'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule